// File: doc/BRIEF.md
# EDID Fetch and Checksum Sequencer

This block fetches a display's identification data one byte at a time, through a simple request/acknowledge read port. A link-level I2C-over-auxiliary-channel engine sits behind that port. On a start pulse the sequencer first reads the extension-count byte. It then reads the 128-byte base block and, if the count is nonzero, a single 128-byte extension block. For each block it keeps a running 8-bit sum, and a block is accepted only when that sum wraps to zero.

Once every block has been read and checked, the sequencer turns to the sink's register space. It reads the compliance test-request register. If the EDID-read test bit is set, it writes the last byte of the final block to the test checksum register, and then writes the acknowledge code to the test response register. Any failed transaction, or any bad block, ends the run at once. The run closes with a one-cycle done pulse and a status code that stays valid until the next start.

Top module: `edid_fetch_seq`

## Requirements
- R1: Every byte read request carries the 7-bit device address 0x50.
- R2: The first read is at offset 126 (the extension count). Offsets 0 to 127 are read next, in ascending order. When the count byte was nonzero, offsets 128 to 255 follow in ascending order. Each request is held with a stable offset until it is acknowledged.
- R3: A block passes only when its 128 bytes sum to 0 modulo 256. If block 0 fails, the run ends with code 2. If block 1 fails, the run ends with code 3. No further request of either kind is made after a failure.
- R4: A read acknowledged with the error flag ends the run with code 1, and no further request follows.
- R5: After all blocks pass, the test-request register at 0x00218 is read. If its bit 2 is set, the byte at offset 127 of the last block read is written to 0x00261, and then 0x04 is written to 0x00260. If bit 2 is clear, no write is made and the run ends with code 0.
- R6: Done is high for exactly one cycle per run, and busy is low in that cycle. The code, pass and fail outputs hold from that cycle until the next accepted start. Pass means code 0; fail means any other code.
- R7: A start pulse that arrives while busy is high has no effect on the request sequence or on the result.
- R8: After reset, busy, done, pass, fail and both request outputs are low.
- R9: A register transaction acknowledged with its error flag ends the run with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a fetch; honoured only when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run ended with code 0 |
| fail_o | output | 1 | Last run ended with a nonzero code |
| code_o | output | 2 | 0 ok, 1 transaction error, 2 block 0 bad, 3 block 1 bad |
| rd_req_o | output | 1 | Byte read request, held until acknowledged |
| rd_dev_o | output | 7 | Device address of the read |
| rd_off_o | output | 8 | Byte offset to read |
| rd_ack_i | input | 1 | Read completed this cycle |
| rd_err_i | input | 1 | Read failed (valid with ack) |
| rd_data_i | input | 8 | Read byte (valid with ack) |
| reg_req_o | output | 1 | Sink register request, held until acknowledged |
| reg_we_o | output | 1 | 1 write, 0 read |
| reg_addr_o | output | 20 | Sink register address |
| reg_wdata_o | output | 8 | Write data |
| reg_ack_i | input | 1 | Register transaction completed this cycle |
| reg_err_i | input | 1 | Register transaction failed (valid with ack) |
| reg_rdata_i | input | 8 | Register read data (valid with ack) |

## Verification
A corrupted byte index or block selector shows on `rd_off_o` at the very next request, as a break in the ascending offset sequence. A sum accumulator that is not cleared, or that adds a byte twice, only shows when the block ends. The symptom is then a wrong code, a wrong total read count, or a wrong byte written to the checksum register, roughly 128 transactions after the fault. A wrong state in the control sequence shows up as a missing or extra register transaction, or as a done pulse that is doubled or absent.

// File: rtl/edid_pkg.sv
// Shared types for the EDID fetch sequencer.
// Assumes: a two-bit result code that is visible at the top ports.
package edid_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_EXT, S_BLK, S_CHK, S_TQ, S_WCK, S_WRSP
    } seq_state_t;

    typedef enum logic [1:0] {
        RC_OK   = 2'd0,
        RC_XFER = 2'd1,
        RC_BAD0 = 2'd2,
        RC_BAD1 = 2'd3
    } res_code_t;
endpackage

// File: rtl/edid_byte_ctr.sv
// Byte index within one block.
// Clear returns the index to zero. Step advances it by one.
// Assumes: clear and step are never asserted together.
module edid_byte_ctr #(
    parameter int N_BYTES = 128,
    localparam int IDX_W  = $clog2(N_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

    // index register: reset/clear to zero, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n || clr) idx <= '0;
        else if (step)     idx <= idx + IDX_W'(1);
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/edid_sum_acc.sv
// Modulo-256 running sum over one block. Also keeps the byte that was
// added while the last flag was high, which is the block's final byte.
// Assumes: clear and add are never asserted together.
module edid_sum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add,
    input  logic       last_in,
    input  logic [7:0] din,
    output logic [7:0] sum,
    output logic [7:0] tail,
    output logic       zero
);
    // wrapping accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sum <= '0;
        else if (add)      sum <= sum + din;
    end

    // capture of the block's final byte
    always_ff @(posedge clk) begin
        if (!rst_n)             tail <= '0;
        else if (add && last_in) tail <= din;
    end

    assign zero = (sum == 8'd0);
endmodule

// File: rtl/edid_fetch_seq.sv
// EDID fetch sequencer.
// Reads the extension count, then one or two blocks, checking each block's
// sum. It then answers the sink's test request with a checksum write-back.
// Assumes: request/ack handshakes, with one outstanding request per port.
module edid_fetch_seq #(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         BLK_BYTES = 128,
    parameter int         EXT_OFF   = 126,
    parameter int         RA_W      = 20,
    parameter logic [RA_W-1:0] TREQ_ADDR = 20'h00218,
    parameter logic [RA_W-1:0] TCK_ADDR  = 20'h00261,
    parameter logic [RA_W-1:0] TRSP_ADDR = 20'h00260,
    parameter int         TREQ_BIT  = 2,
    parameter logic [7:0] TRSP_CODE = 8'h04,
    localparam int IDX_W = $clog2(BLK_BYTES),
    localparam int OFF_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic [1:0]       code_o,
    output logic             rd_req_o,
    output logic [6:0]       rd_dev_o,
    output logic [OFF_W-1:0] rd_off_o,
    input  logic             rd_ack_i,
    input  logic             rd_err_i,
    input  logic [7:0]       rd_data_i,
    output logic             reg_req_o,
    output logic             reg_we_o,
    output logic [RA_W-1:0]  reg_addr_o,
    output logic [7:0]       reg_wdata_o,
    input  logic             reg_ack_i,
    input  logic             reg_err_i,
    input  logic [7:0]       reg_rdata_i
);
    import edid_pkg::*;

    localparam logic [OFF_W-1:0] EXT_OFFSET = OFF_W'(EXT_OFF);

    seq_state_t       state, nxt_state;
    res_code_t        code_q, fin_code;
    logic             blk1_q, ext_q, res_vld_q;
    logic             fin, blk_start, rd_fire, reg_fire, step;
    logic [IDX_W-1:0] idx;
    logic             idx_last, sum_zero;
    logic [7:0]       sum, tail;

    assign rd_fire  = rd_req_o && rd_ack_i;
    assign reg_fire = reg_req_o && reg_ack_i;
    assign step     = (state == S_BLK) && rd_fire && !rd_err_i;

    edid_byte_ctr #(.N_BYTES(BLK_BYTES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(blk_start), .step(step),
        .idx(idx), .last(idx_last)
    );

    edid_sum_acc u_sum (
        .clk(clk), .rst_n(rst_n), .clr(blk_start), .add(step),
        .last_in(idx_last), .din(rd_data_i),
        .sum(sum), .tail(tail), .zero(sum_zero)
    );

    // request outputs decoded from the current state
    always_comb begin
        rd_req_o    = (state == S_EXT) || (state == S_BLK);
        rd_dev_o    = DEV_ADDR;
        rd_off_o    = (state == S_EXT) ? EXT_OFFSET : {blk1_q, idx};
        reg_req_o   = (state == S_TQ) || (state == S_WCK) || (state == S_WRSP);
        reg_we_o    = (state == S_WCK) || (state == S_WRSP);
        reg_addr_o  = (state == S_WCK) ? TCK_ADDR :
                      (state == S_WRSP) ? TRSP_ADDR : TREQ_ADDR;
        reg_wdata_o = (state == S_WCK) ? tail :
                      (state == S_WRSP) ? TRSP_CODE : 8'd0;
    end

    // next-state, finish and block-start decisions
    always_comb begin
        nxt_state = state;
        fin       = 1'b0;
        fin_code  = RC_OK;
        blk_start = 1'b0;
        case (state)
            S_IDLE: if (start_i) nxt_state = S_EXT;
            S_EXT: if (rd_fire) begin
                if (rd_err_i) begin fin = 1'b1; fin_code = RC_XFER; end
                else begin blk_start = 1'b1; nxt_state = S_BLK; end
            end
            S_BLK: if (rd_fire) begin
                if (rd_err_i)      begin fin = 1'b1; fin_code = RC_XFER; end
                else if (idx_last) nxt_state = S_CHK;
            end
            S_CHK: begin
                if (!sum_zero) begin
                    fin = 1'b1;
                    fin_code = blk1_q ? RC_BAD1 : RC_BAD0;
                end else if (ext_q && !blk1_q) begin
                    blk_start = 1'b1;
                    nxt_state = S_BLK;
                end else nxt_state = S_TQ;
            end
            S_TQ: if (reg_fire) begin
                if (reg_err_i)                  begin fin = 1'b1; fin_code = RC_XFER; end
                else if (reg_rdata_i[TREQ_BIT]) nxt_state = S_WCK;
                else                            fin = 1'b1;
            end
            S_WCK: if (reg_fire) begin
                if (reg_err_i) begin fin = 1'b1; fin_code = RC_XFER; end
                else nxt_state = S_WRSP;
            end
            S_WRSP: if (reg_fire) begin
                fin = 1'b1;
                fin_code = reg_err_i ? RC_XFER : RC_OK;
            end
            default: nxt_state = S_IDLE;
        endcase
        if (fin) nxt_state = S_IDLE;
    end

    // sequencer state, block selector, extension flag and held result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            blk1_q    <= 1'b0;
            ext_q     <= 1'b0;
            done_o    <= 1'b0;
            res_vld_q <= 1'b0;
            code_q    <= RC_OK;
        end else begin
            state  <= nxt_state;
            done_o <= fin;
            if (state == S_IDLE && start_i) begin
                res_vld_q <= 1'b0;
                code_q    <= RC_OK;
            end
            if (state == S_EXT && rd_fire) begin
                ext_q  <= (rd_data_i != 8'd0);
                blk1_q <= 1'b0;
            end
            if (state == S_CHK && blk_start) blk1_q <= 1'b1;
            if (fin) begin
                res_vld_q <= 1'b1;
                code_q    <= fin_code;
            end
        end
    end

    assign busy_o = (state != S_IDLE);
    assign code_o = code_q;
    assign pass_o = res_vld_q && (code_q == RC_OK);
    assign fail_o = res_vld_q && (code_q != RC_OK);
endmodule

// File: rtl/edid_fetch_seq_chk.sv
// Protocol checker for the EDID fetch sequencer; attached by bind below.
// Assumes: the default 128-byte block geometry for the offset-step check.
module edid_fetch_seq_chk #(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         BLK_BYTES = 128,
    localparam int OFF_W = $clog2(BLK_BYTES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             rd_req_o,
    input logic [6:0]       rd_dev_o,
    input logic [OFF_W-1:0] rd_off_o,
    input logic             rd_ack_i,
    input logic             rd_err_i,
    input logic             reg_req_o,
    input logic             reg_ack_i,
    input logic             reg_err_i
);
    localparam logic [OFF_W-1:0] B0_STEP_END = OFF_W'(BLK_BYTES - 2);
    localparam logic [OFF_W-1:0] B1_FIRST    = OFF_W'(BLK_BYTES);
    localparam logic [OFF_W-1:0] B1_LAST     = OFF_W'(2 * BLK_BYTES - 1);

    // R1: device address on every read
    assert_rd_dev_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_dev_o == DEV_ADDR);

    // R2: a pending read keeps its offset
    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_off_o));

    // R2: inside a block, the offset steps by one after each good byte
    assert_off_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ack_i && !rd_err_i &&
        (rd_off_o < B0_STEP_END || (rd_off_o >= B1_FIRST && rd_off_o < B1_LAST))
        |=> rd_req_o && rd_off_o == $past(rd_off_o) + OFF_W'(1));

    // R4: a failed read ends all requests
    assert_rd_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ack_i && rd_err_i |=> !rd_req_o && !reg_req_o);

    // R9: a failed register transaction ends all requests
    assert_reg_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_o && reg_ack_i && reg_err_i |=> !rd_req_o && !reg_req_o);

    // R6: done lasts one cycle, and the block is idle while it is high
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: no request while idle; never both ports at once
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o && !reg_req_o);
    assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && reg_req_o));
endmodule

bind edid_fetch_seq edid_fetch_seq_chk #(
    .DEV_ADDR(DEV_ADDR), .BLK_BYTES(BLK_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .rd_req_o(rd_req_o), .rd_dev_o(rd_dev_o), .rd_off_o(rd_off_o),
    .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i),
    .reg_req_o(reg_req_o), .reg_ack_i(reg_ack_i), .reg_err_i(reg_err_i)
);

// File: tb/edid_fetch_seq_bench.sv
// Bench: a modelled sink with random acknowledge delays and fault injection.
// Each run's expected results are computed from the requirements.
module edid_fetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, pass_o, fail_o;
    logic [1:0]  code_o;
    logic        rd_req_o;
    logic [6:0]  rd_dev_o;
    logic [7:0]  rd_off_o;
    logic        rd_ack_i = 1'b0, rd_err_i = 1'b0;
    logic [7:0]  rd_data_i = 8'd0;
    logic        reg_req_o, reg_we_o;
    logic [19:0] reg_addr_o;
    logic [7:0]  reg_wdata_o;
    logic        reg_ack_i = 1'b0, reg_err_i = 1'b0;
    logic [7:0]  reg_rdata_i = 8'd0;

    always #2 clk = ~clk;

    edid_fetch_seq u_edid_fetch_seq (.*);

    logic [7:0]  mem [256];
    logic [7:0]  treq;
    logic [19:0] wr_addr [4];
    logic [7:0]  wr_data [4];
    int inj_rd = -1, inj_reg = -1;
    int rd_n = 0, reg_n = 0, wr_n = 0, offs_bad = 0, dev_bad = 0;
    int rd_wait = 0, reg_wait = 0;
    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] blk_sum(input int base);
        logic [7:0] s = 8'd0;
        for (int i = 0; i < 128; i++) s = s + mem[base + i];
        return s;
    endfunction

    // modelled sink: byte read port
    initial forever begin
        @(negedge clk);
        if (rd_ack_i) begin
            rd_ack_i = 1'b0; rd_err_i = 1'b0;
        end else if (rd_req_o) begin
            if (rd_wait > 0) rd_wait--;
            else begin
                if (int'(rd_off_o) != ((rd_n == 0) ? 126 : rd_n - 1)) offs_bad++;
                if (rd_dev_o != 7'h50) dev_bad++;
                rd_ack_i  = 1'b1;
                rd_data_i = mem[rd_off_o];
                rd_err_i  = (rd_n == inj_rd);
                rd_n++;
                rd_wait = int'($urandom % 3);
            end
        end
    end

    // modelled sink: register port
    initial forever begin
        @(negedge clk);
        if (reg_ack_i) begin
            reg_ack_i = 1'b0; reg_err_i = 1'b0;
        end else if (reg_req_o) begin
            if (reg_wait > 0) reg_wait--;
            else begin
                if (reg_we_o && wr_n < 4) begin
                    wr_addr[wr_n] = reg_addr_o;
                    wr_data[wr_n] = reg_wdata_o;
                    wr_n++;
                end
                reg_ack_i   = 1'b1;
                reg_rdata_i = (reg_addr_o == 20'h00218) ? treq : 8'hA5;
                reg_err_i   = (reg_n == inj_reg);
                reg_n++;
                reg_wait = int'($urandom % 3);
            end
        end
    end

    task automatic run(input int ext, input bit bad0, input bit bad1, input bit tbit,
                       input int irp, input int igp);
        int  n_rd, n_reg, code, dones, cyc;
        bit  has_ext, good0, good1;
        logic [7:0] tailb;
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        mem[126] = 8'(ext);
        mem[127] = 8'd0; mem[127] = -blk_sum(0);
        mem[255] = 8'd0; mem[255] = -blk_sum(128);
        if (bad0) mem[127] = mem[127] ^ 8'h10;
        if (bad1) mem[200] = mem[200] + 8'd3;
        treq = 8'($urandom);
        treq[2] = tbit;
        // expected values
        has_ext = (mem[126] != 8'd0);
        good0 = (blk_sum(0) == 8'd0);
        good1 = (blk_sum(128) == 8'd0);
        n_rd = (has_ext && good0) ? 257 : 129;
        n_reg = 0;
        if (irp >= 0 && irp < n_rd) begin code = 1; n_rd = irp + 1; end
        else if (!good0) code = 2;
        else if (has_ext && !good1) code = 3;
        else begin
            n_reg = treq[2] ? 3 : 1;
            code = 0;
            if (igp >= 0 && igp < n_reg) begin code = 1; n_reg = igp + 1; end
        end
        tailb = has_ext ? mem[255] : mem[127];
        inj_rd = irp; inj_reg = igp;
        rd_n = 0; reg_n = 0; wr_n = 0; offs_bad = 0; dev_bad = 0;
        // launch
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        dones = 0; cyc = 0;
        while (cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 25 && busy_o) start_i = 1'b1;   // R7: ignored while busy
            else start_i = 1'b0;
            if (done_o) begin
                dones++;
                check(!busy_o, "R6 busy low with done", int'(busy_o), 0);
                break;
            end
        end
        if (dones == 0) check(1'b0, "R6 watchdog: no done", cyc, 4000);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check(dones == 1, "R6 done pulse count", dones, 1);
        check(int'(code_o) == code, "R3/R4/R9 code", int'(code_o), code);
        check(pass_o == (code == 0) && fail_o == (code != 0), "R6 pass/fail held",
              int'({pass_o, fail_o}), (code == 0) ? 2 : 1);
        check(rd_n == n_rd, "R2 R7 read count", rd_n, n_rd);
        check(offs_bad == 0, "R2 offset order", offs_bad, 0);
        check(dev_bad == 0, "R1 device address", dev_bad, 0);
        check(reg_n == n_reg, "R5 register transactions", reg_n, n_reg);
        if (n_reg >= 2)
            check(wr_addr[0] == 20'h00261 && wr_data[0] == tailb,
                  "R5 checksum write", int'(wr_data[0]), int'(tailb));
        if (n_reg >= 3)
            check(wr_addr[1] == 20'h00260 && wr_data[1] == 8'h04,
                  "R5 response write", int'(wr_data[1]), 4);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !pass_o && !fail_o && !rd_req_o && !reg_req_o,
              "R8 reset state", int'({busy_o, done_o, pass_o, fail_o, rd_req_o, reg_req_o}), 0);
        // directed corners
        run(0, 0, 0, 1, -1, -1);   // R5 single block, write-back
        run(1, 0, 0, 1, -1, -1);   // R2 R5 extension, write-back from block 1
        run(2, 0, 0, 0, -1, -1);   // R5 no test bit, no writes
        run(1, 1, 0, 1, -1, -1);   // R3 bad block 0 stops early
        run(1, 0, 1, 1, -1, -1);   // R3 bad block 1
        run(0, 1, 0, 0, -1, -1);   // R3 bad block 0 without extension
        run(1, 0, 0, 1,  0, -1);   // R4 error on count read
        run(1, 0, 0, 1, 200, -1);  // R4 error inside block 1
        run(0, 0, 0, 1, -1, 0);    // R9 error on test-request read
        run(0, 0, 0, 1, -1, 1);    // R9 error on checksum write
        run(1, 0, 0, 1, -1, 2);    // R9 error on response write
        // random mix
        for (int r = 0; r < 20; r++) begin
            run(($urandom % 2) ? int'($urandom % 4) : 0,
                ($urandom % 5) == 0, ($urandom % 5) == 0, 1'($urandom % 2),
                (($urandom % 6) == 0) ? int'($urandom % 260) : -1,
                (($urandom % 6) == 0) ? int'($urandom % 3) : -1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule